// File: doc/BRIEF.md
# Framed Packet Serial Transmitter

This block takes one byte at a time over a valid/ready handshake and sends it on a single asynchronous serial line as a packet of four frames. Two fixed sync bytes go first, 0x99 and then 0x88. The payload byte follows, and then its bitwise inverse, so that a receiver can lock onto the packet and check the payload. Each frame is a low start bit, eight data bits sent least-significant bit first, and a high stop bit. The line idles high.

Bit timing comes from a divider that counts `CLKS_PER_BIT` clock cycles per bit. The default of 1000 gives a 1 kbps line from a 1 MHz clock. The four frames follow each other with no idle gap, so one packet occupies the line for exactly 40 bit times. `in_ready` stays low from the accepting edge until the fourth stop bit has ended. `busy` is high for that same span.

Top module: `pkt_serial_tx`

## Requirements
- R1: After reset `tx_line` is 1, `busy` is 0 and `in_ready` is 1.
- R2: A byte is taken at a rising edge where `in_valid` and `in_ready` are both 1. From that edge `tx_line` is 0 (start bit), `busy` is 1 and `in_ready` is 0.
- R3: Every bit on `tx_line` holds its value for exactly `CLKS_PER_BIT` clock cycles.
- R4: Each frame is a 0 start bit, then data bits 0 through 7 in that order (LSB first), then a 1 stop bit.
- R5: The four frames of a packet carry, in order, `SYNC_A` (default 0x99), `SYNC_B` (default 0x88), the accepted byte, and the bitwise inverse of the accepted byte.
- R6: The frames of a packet follow one another with no idle cycle. `in_ready` is low and `busy` is high for exactly 40×`CLKS_PER_BIT` cycles after the accepting edge, and then `in_ready` returns to 1 and `busy` to 0.
- R7: `in_valid` and `in_data` have no effect while a packet is in progress. The packet in flight is unchanged and no additional packet is sent.
- R8: Whenever `busy` is 0, `tx_line` is 1.
- R9: With `in_valid` held high, the next byte is accepted at the edge after `in_ready` rises. This leaves exactly one idle-high clock cycle between packets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte offered on `in_data` |
| in_ready | output | 1 | Block can take a byte (registered) |
| in_data | input | DATA_W | Payload byte |
| busy | output | 1 | Packet in progress (registered) |
| tx_line | output | 1 | Serial output, idle high (registered) |

## Verification
The assertions assume that `in_valid` and `in_data` are driven to known values whenever reset is low. They make no assumption about when `in_valid` rises or how long it stays high, because the block must ignore offers made while it is busy. The stimulus changes inputs only on falling clock edges. It deliberately raises `in_valid` with a stray byte in the middle of a packet, and it holds `in_valid` high across the end of a packet so that the next byte is taken without a gap. A bench-side receiver rebuilds every frame from the line using the known bit length and compares it with the bytes the driver queued.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;

  // Frame slot within one packet; order is the order on the wire
  typedef enum logic [1:0] {
    FR_SYNC_A = 2'd0,
    FR_SYNC_B = 2'd1,
    FR_DATA   = 2'd2,
    FR_CHECK  = 2'd3
  } frame_sel_e;

  localparam int FRAMES_PER_PKT = 4;

endpackage

// File: rtl/pkt_bit_timer.sv
module pkt_bit_timer #(
  parameter int CLKS_PER_BIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic bit_end
);
  localparam int CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_BIT - 1);

  logic [CNT_W-1:0] cnt_q;

  assign bit_end = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (restart || !run || cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  // R3
  wrap_after_end_chk: assert property (@(posedge clk) disable iff (rst)
    bit_end |=> (cnt_q == '0));

endmodule

// File: rtl/pkt_frame_ser.sv
module pkt_frame_ser #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_byte,
  input  logic              bit_end,
  output logic              line,
  output logic              running,
  output logic              frame_done
);
  localparam int BITS  = DATA_W + 2;
  localparam int BCW   = $clog2(BITS + 1);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(BITS - 1);

  logic [DATA_W:0] sh_q;
  logic [BCW-1:0]  bcnt_q;

  assign frame_done = running && bit_end && (bcnt_q == LAST_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      line    <= 1'b1;
      running <= 1'b0;
      bcnt_q  <= '0;
      sh_q    <= '1;
    end else if (load) begin
      line    <= 1'b0;
      sh_q    <= {1'b1, load_byte};
      bcnt_q  <= '0;
      running <= 1'b1;
    end else if (running && bit_end) begin
      if (bcnt_q == LAST_BIT) begin
        running <= 1'b0;
        line    <= 1'b1;
      end else begin
        line   <= sh_q[0];
        sh_q   <= {1'b1, sh_q[DATA_W:1]};
        bcnt_q <= bcnt_q + 1'b1;
      end
    end
  end

  // R3
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (running && !bit_end && !load) |=> $stable(line));

  // R4
  start_low_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> !line);

  // R4
  stop_high_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> line);

  // R4
  bit_count_chk: assert property (@(posedge clk) disable iff (rst)
    bcnt_q <= LAST_BIT);

endmodule

// File: rtl/pkt_sequencer.sv
module pkt_sequencer
  import pkt_tx_pkg::*;
#(
  parameter int              DATA_W = 8,
  parameter logic [DATA_W-1:0] SYNC_A = 8'h99,
  parameter logic [DATA_W-1:0] SYNC_B = 8'h88
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              frame_done,
  output logic              in_ready,
  output logic              busy,
  output logic              load,
  output logic [DATA_W-1:0] load_byte
);
  frame_sel_e        idx_q;
  logic [DATA_W-1:0] payload_q;
  logic              accept;
  logic              pkt_last;

  assign accept   = in_valid && in_ready;
  assign pkt_last = frame_done && (idx_q == FR_CHECK);
  assign load     = accept || (frame_done && idx_q != FR_CHECK);

  always_comb begin
    if (accept) begin
      load_byte = SYNC_A;
    end else begin
      unique case (idx_q)
        FR_SYNC_A: load_byte = SYNC_B;
        FR_SYNC_B: load_byte = payload_q;
        FR_DATA:   load_byte = ~payload_q;
        default:   load_byte = SYNC_A;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      in_ready  <= 1'b1;
      idx_q     <= FR_SYNC_A;
      payload_q <= '0;
    end else if (accept) begin
      busy      <= 1'b1;
      in_ready  <= 1'b0;
      idx_q     <= FR_SYNC_A;
      payload_q <= in_data;
    end else if (frame_done) begin
      if (pkt_last) begin
        busy     <= 1'b0;
        in_ready <= 1'b1;
      end else begin
        idx_q <= frame_sel_e'(idx_q + 2'd1);
      end
    end
  end

  // R6
  ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !in_ready);

  // R6
  release_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_last |=> (in_ready && !busy));

  // R7
  payload_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> $stable(payload_q));

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy && !in_ready));

endmodule

// File: rtl/pkt_serial_tx.sv
module pkt_serial_tx #(
  parameter int                CLKS_PER_BIT = 1000,
  parameter int                DATA_W       = 8,
  parameter logic [DATA_W-1:0] SYNC_A       = 8'h99,
  parameter logic [DATA_W-1:0] SYNC_B       = 8'h88
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              busy,
  output logic              tx_line
);
  logic              load;
  logic [DATA_W-1:0] load_byte;
  logic              bit_end;
  logic              running;
  logic              frame_done;

  pkt_sequencer #(
    .DATA_W (DATA_W),
    .SYNC_A (SYNC_A),
    .SYNC_B (SYNC_B)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .frame_done (frame_done),
    .in_ready   (in_ready),
    .busy       (busy),
    .load       (load),
    .load_byte  (load_byte)
  );

  pkt_bit_timer #(
    .CLKS_PER_BIT (CLKS_PER_BIT)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (running),
    .restart (load),
    .bit_end (bit_end)
  );

  pkt_frame_ser #(
    .DATA_W (DATA_W)
  ) u_ser (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .load_byte  (load_byte),
    .bit_end    (bit_end),
    .line       (tx_line),
    .running    (running),
    .frame_done (frame_done)
  );

  // R8
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx_line);

  // R6
  busy_covers_line_chk: assert property (@(posedge clk) disable iff (rst)
    running |-> busy);

endmodule

// File: tb/pkt_serial_tx_bench.sv
module pkt_serial_tx_bench;
  localparam int N      = 4;
  localparam int PKT_CY = 40 * N;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, busy, tx_line;

  int ntests = 0;
  int nfail  = 0;
  bit done   = 1'b0;
  bit rst_done = 1'b0;

  logic [7:0] exp_q[$];
  int frames_rx = 0;
  int frames_tx = 0;
  int last_gap  = -1;

  always #4 clk = ~clk;

  pkt_serial_tx #(.CLKS_PER_BIT(N)) u_pkt_serial_tx (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .busy     (busy),
    .tx_line  (tx_line)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: rebuilds frames from the line, pops expected bytes
  int         gap;
  int         fpos = 0;
  logic [9:0] fr;
  logic       first;
  bit         steady;
  logic [7:0] want;

  initial begin
    wait (rst_done);
    forever begin
      gap = 0;
      @(negedge clk);
      while (tx_line) begin
        gap++;
        @(negedge clk);
      end
      steady = 1'b1;
      for (int i = 0; i < 10; i++) begin
        first = tx_line;
        repeat (N - 1) @(negedge clk);
        if (tx_line !== first) steady = 1'b0;
        fr[i] = first;
        if (i < 9) @(negedge clk);
      end
      frames_rx++;
      chk(fr[0] == 1'b0, "R4", "start bit", fr[0], 0);
      chk(fr[9] == 1'b1, "R4", "stop bit", fr[9], 1);
      chk(steady, "R3", "bit held for CLKS_PER_BIT", steady, 1);
      if (fpos != 0) chk(gap == 0, "R6", "gap inside packet", gap, 0);
      else last_gap = gap;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", "unexpected frame", fr[8:1], 0);
      end else begin
        want = exp_q.pop_front();
        chk(fr[8:1] == want, "R5", "frame byte", fr[8:1], want);
      end
      fpos = (fpos + 1) % 4;
    end
  end

  task automatic push_pkt(input logic [7:0] d);
    exp_q.push_back(8'h99);
    exp_q.push_back(8'h88);
    exp_q.push_back(d);
    exp_q.push_back(~d);
    frames_tx += 4;
  endtask

  task automatic start_pkt(input logic [7:0] d, input bit hold);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    push_pkt(d);
    @(negedge clk);
    if (!hold) in_valid = 1'b0;
    chk(tx_line == 1'b0, "R2", "start bit after accept", tx_line, 0);
    chk(busy == 1'b1, "R2", "busy after accept", busy, 1);
    chk(in_ready == 1'b0, "R2", "ready after accept", in_ready, 0);
  endtask

  // Counts low-ready cycles; optionally injects a stray offer (R7)
  task automatic finish_pkt(input int junk_at);
    int cnt;
    bit busy_ok;
    cnt = 0;
    busy_ok = 1'b1;
    while (!in_ready) begin
      cnt++;
      if (!busy) busy_ok = 1'b0;
      if (cnt == junk_at) begin
        in_valid = 1'b1;
        in_data  = 8'h5A;
      end
      if (cnt == junk_at + 10) in_valid = 1'b0;
      @(negedge clk);
    end
    chk(cnt == PKT_CY, "R6", "ready low cycles", cnt, PKT_CY);
    chk(busy_ok, "R6", "busy through packet", busy_ok, 1);
    chk(busy == 1'b0, "R6", "busy after packet", busy, 0);
    chk(tx_line == 1'b1, "R8", "line idle after packet", tx_line, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(tx_line == 1'b1, "R1", "line after reset", tx_line, 1);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);
    rst_done = 1'b1;
    repeat (7) @(negedge clk);
    chk(tx_line == 1'b1, "R8", "line idle before traffic", tx_line, 1);

    start_pkt(8'h00, 1'b0); finish_pkt(-100);
    start_pkt(8'hFF, 1'b0); finish_pkt(-100);
    repeat (3) @(negedge clk);
    start_pkt(8'hA5, 1'b0); finish_pkt(-100);
    // R7: stray offer mid-packet
    start_pkt(8'h81, 1'b0); finish_pkt(30);
    repeat (5) @(negedge clk);
    chk(busy == 1'b0, "R7", "no packet from stray offer", busy, 0);
    chk(tx_line == 1'b1, "R7", "line idle after stray offer", tx_line, 1);
    // R9: valid held across packet end
    start_pkt(8'h12, 1'b1);
    in_data = 8'hED;
    push_pkt(8'hED);
    finish_pkt(-100);
    @(negedge clk);
    in_valid = 1'b0;
    chk(tx_line == 1'b0, "R9", "next start one cycle after ready", tx_line, 0);
    chk(in_ready == 1'b0, "R9", "second byte taken", in_ready, 0);
    finish_pkt(-100);
    start_pkt(8'h3C, 1'b0); finish_pkt(-100);
    repeat (20) @(negedge clk);
    chk(last_gap == 1, "R9", "idle cycles between packets", last_gap, 1);
    chk(exp_q.size() == 0, "R5", "frames left unsent", exp_q.size(), 0);
    chk(frames_rx == frames_tx, "R7", "frame count", frames_rx, frames_tx);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      ntests++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

endmodule